// File: doc/BRIEF.md
# External Bus Strobe Generator

This block times a multiplexed external memory bus. It works over a machine cycle of twelve oscillator periods: six states of two phases each. From a slot index supplied by the core's cycle sequencer, it produces an address latch strobe, an active-low read strobe for external code, and a select that tells the bus driver whether the shared low byte carries an address or data. It also picks the byte that drives the high-address port. All outputs are registered. Each output reflects the inputs presented one clock earlier.

The slot index counts from 0 to 11, where slot = 2*(state-1) + (phase-1). The core holds its cycle flags steady for a whole machine cycle. These flags are: external data access, wide (pointer) or narrow (register-indirect) addressing, code-table read, and a strobe-disable bit. Whether code comes from the external bus is decided inside the block. It uses the external-access pin and the fetch address.

With no bus activity and the disable bit clear, the latch strobe runs freely at one-sixth of the oscillator rate. It can be silenced (held high) outside table reads and data moves. During a data access it drops one pulse and both code-read strobes.

Top module: `xbus_strobe_gen`

## Requirements
- R1: While reset is high, and on the cycle after it, ale is 0, psen_n is 1, lo_is_addr is 0 and hi_addr is 0x00.
- R2: With no data access and the latch strobe not silenced, ale is 1 in exactly the cycles following slots 1, 2, 7 and 8. This gives two pulses per machine cycle, each two periods wide.
- R3: In a machine cycle with xdata_cyc = 1, the pulse at slots 1 and 2 is omitted (ale 0), and the pulse at slots 7 and 8 is still produced.
- R4: With ale_off = 1, code executing internally, and neither xdata_cyc nor tbl_rd set, ale is held at 1 for every slot. With ale_off = 1 and tbl_rd or xdata_cyc set, ale follows R2 or R3.
- R5: ale_off has no effect while code is fetched from the external bus; ale then follows R2 and R3.
- R6: While code is fetched externally and there is no data access, psen_n is 0 in the cycles following slots 3, 4, 5, 9, 10 and 11 and 1 otherwise.
- R7: psen_n stays 1 for the whole of any machine cycle with xdata_cyc = 1, and whenever code is fetched internally.
- R8: Code is fetched externally when ea_pin = 0 for any fetch_addr. With ea_pin = 1 it is fetched externally only when fetch_addr is 0x2000 or above; 0x0000 to 0x1FFF stay internal.
- R9: In a data access cycle with xdata_wide = 1, hi_addr equals dptr_hi.
- R10: In a data access cycle with xdata_wide = 0, hi_addr equals p2_reg.
- R11: Outside data access cycles, hi_addr equals fetch_addr[15:8] when code is fetched externally and p2_reg otherwise.
- R12: lo_is_addr is 1 after slots 6, 7 and 8 in a data access cycle. It is 1 after slots 0, 1, 2, 6, 7 and 8 in an external code cycle without data access, and 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| slot | input | 4 | Position within the machine cycle, 0 to 11 |
| ea_pin | input | 1 | External-access strap; 0 forces every fetch onto the bus |
| fetch_addr | input | 16 | Address of the current code fetch |
| xdata_cyc | input | 1 | Current machine cycle is an external data access |
| xdata_wide | input | 1 | Data access uses the 16-bit pointer (1) or an 8-bit register (0) |
| dptr_hi | input | 8 | Upper byte of the data pointer |
| tbl_rd | input | 1 | Current machine cycle performs a code-table read |
| ale_off | input | 1 | Silences the latch strobe outside moves and table reads |
| p2_reg | input | 8 | Value of the high-port output register |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| lo_is_addr | output | 1 | 1 while the low byte carries an address, 0 while it carries data |
| hi_addr | output | 8 | Byte driven on the high-address port |

## Verification
Two conditions are hard to reach from the ports. The first is the silenced strobe: it needs ale_off set, internal execution (ea_pin high and a fetch address below the internal limit), and neither a data move nor a table read, all held for a whole machine cycle. The second is the fetch boundary at 0x1FFF and 0x2000, which random 16-bit addresses almost never land on. Directed machine cycles set up each of these explicitly. Random cycles then draw the flags with biased probabilities so that ale_off meets internal execution often. They also mix data accesses with both external and internal code, so the dropped pulses and the register-versus-pointer high byte appear under every combination.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  parameter int MC_SLOTS   = 12;             // oscillator periods per machine cycle
  parameter int NUM_PULSES = 2;              // latch pulses per machine cycle
  parameter int LATCH_LEN  = 2;              // periods the latch strobe stays high
  parameter int ADDR_W     = 16;
  parameter int DATA_W     = 8;
  parameter int INT_CODE_SIZE = 8192;        // bytes of on-chip code space

  localparam int SLOT_W = $clog2(MC_SLOTS);
  localparam int SPAN   = MC_SLOTS / NUM_PULSES;   // periods between pulses

  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/ebus_fetch_decode.sv
module ebus_fetch_decode
  import ebus_pkg::*;
#(
  parameter int AW        = ADDR_W,
  parameter int CODE_SIZE = INT_CODE_SIZE
) (
  input  logic          ea_pin,
  input  logic [AW-1:0] fetch_addr,
  output logic          code_ext
);
  localparam logic [AW:0] LIMIT = (AW+1)'(CODE_SIZE);

  // strap low: every fetch goes out; strap high: only above on-chip space
  always_comb begin
    code_ext = !ea_pin || ({1'b0, fetch_addr} >= LIMIT);
  end
endmodule

// File: rtl/ebus_strobe_gen.sv
module ebus_strobe_gen
  import ebus_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  slot_t slot,
  input  logic  code_ext,
  input  logic  xdata_cyc,
  input  logic  tbl_rd,
  input  logic  ale_off,
  output logic  ale_q,
  output logic  psen_n_q,
  output logic  lo_addr_q
);
  logic [NUM_PULSES-1:0] win_latch;
  logic [NUM_PULSES-1:0] win_read;
  logic [NUM_PULSES-1:0] win_addr;

  // each half machine cycle: address set-up, latch pulse, then read window
  for (genvar k = 0; k < NUM_PULSES; k++) begin : g_win
    localparam int LS = 1 + k * SPAN;
    assign win_addr[k]  = (int'(slot) >= LS - 1) && (int'(slot) < LS + LATCH_LEN);
    assign win_latch[k] = (int'(slot) >= LS) && (int'(slot) < LS + LATCH_LEN);
    assign win_read[k]  = (int'(slot) >= LS + LATCH_LEN) && (int'(slot) < LS + SPAN - 1);
  end

  logic ale_raw, ale_gate, ale_d, psen_d, lo_d;

  always_comb begin
    // data access: first pulse of the cycle is dropped
    ale_raw  = win_latch[0] ? !xdata_cyc : (|win_latch);
    ale_gate = !ale_off || code_ext || xdata_cyc || tbl_rd;
    ale_d    = ale_gate ? ale_raw : 1'b1;
    psen_d   = !(code_ext && !xdata_cyc && (|win_read));
    if (xdata_cyc)
      lo_d = |(win_addr >> 1);
    else if (code_ext)
      lo_d = |win_addr;
    else
      lo_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q     <= 1'b0;
      psen_n_q  <= 1'b1;
      lo_addr_q <= 1'b0;
    end else begin
      ale_q     <= ale_d;
      psen_n_q  <= psen_d;
      lo_addr_q <= lo_d;
    end
  end

  AST_DATA_DROP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(xdata_cyc) && ($past(slot) == slot_t'(1))) |-> !ale_q); // R3

  AST_OFF_HELD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ale_off && !code_ext && !xdata_cyc && !tbl_rd)) |-> ale_q); // R4

  AST_NO_READ_IN_DATA: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(xdata_cyc)) |-> psen_n_q); // R7

  AST_DATA_LO_EARLY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(xdata_cyc) && (int'($past(slot)) < SPAN)) |-> !lo_addr_q); // R12
endmodule

// File: rtl/ebus_hi_mux.sv
module ebus_hi_mux
  import ebus_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          code_ext,
  input  logic          xdata_cyc,
  input  logic          xdata_wide,
  input  logic [DW-1:0] fetch_hi,
  input  logic [DW-1:0] dptr_hi,
  input  logic [DW-1:0] p2_reg,
  output logic [DW-1:0] hi_q
);
  logic [DW-1:0] hi_d;

  always_comb begin
    if (xdata_cyc)
      hi_d = xdata_wide ? dptr_hi : p2_reg;
    else if (code_ext)
      hi_d = fetch_hi;
    else
      hi_d = p2_reg;
  end

  always_ff @(posedge clk) begin
    if (rst) hi_q <= '0;
    else     hi_q <= hi_d;
  end

  AST_NARROW_P2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(xdata_cyc && !xdata_wide)) |-> (hi_q == $past(p2_reg))); // R10

  AST_WIDE_PTR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(xdata_cyc && xdata_wide)) |-> (hi_q == $past(dptr_hi))); // R9
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import ebus_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SLOT_W-1:0]      slot,
  input  logic                   ea_pin,
  input  logic [ADDR_W-1:0]      fetch_addr,
  input  logic                   xdata_cyc,
  input  logic                   xdata_wide,
  input  logic [DATA_W-1:0]      dptr_hi,
  input  logic                   tbl_rd,
  input  logic                   ale_off,
  input  logic [DATA_W-1:0]      p2_reg,
  output logic                   ale,
  output logic                   psen_n,
  output logic                   lo_is_addr,
  output logic [DATA_W-1:0]      hi_addr
);
  logic code_ext;

  ebus_fetch_decode #(.AW(ADDR_W), .CODE_SIZE(INT_CODE_SIZE)) i_decode (
    .ea_pin     (ea_pin),
    .fetch_addr (fetch_addr),
    .code_ext   (code_ext)
  );

  ebus_strobe_gen i_strobe (
    .clk       (clk),
    .rst       (rst),
    .slot      (slot),
    .code_ext  (code_ext),
    .xdata_cyc (xdata_cyc),
    .tbl_rd    (tbl_rd),
    .ale_off   (ale_off),
    .ale_q     (ale),
    .psen_n_q  (psen_n),
    .lo_addr_q (lo_is_addr)
  );

  ebus_hi_mux #(.DW(DATA_W)) i_hi (
    .clk        (clk),
    .rst        (rst),
    .code_ext   (code_ext),
    .xdata_cyc  (xdata_cyc),
    .xdata_wide (xdata_wide),
    .fetch_hi   (fetch_addr[ADDR_W-1 -: DATA_W]),
    .dptr_hi    (dptr_hi),
    .p2_reg     (p2_reg),
    .hi_q       (hi_addr)
  );

  AST_READ_NEEDS_EXT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !psen_n) |-> $past(code_ext)); // R8
endmodule

// File: tb/test_xbus_strobe_gen.sv
module test_xbus_strobe_gen;
  localparam int CLK_P = 10;
  localparam int WATCHDOG_CYC = 200000;
  localparam int RAND_CYCLES = 300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  slot = '0;
  logic        ea_pin = 1'b1;
  logic [15:0] fetch_addr = '0;
  logic        xdata_cyc = 1'b0;
  logic        xdata_wide = 1'b0;
  logic [7:0]  dptr_hi = '0;
  logic        tbl_rd = 1'b0;
  logic        ale_off = 1'b0;
  logic [7:0]  p2_reg = '0;
  logic        ale, psen_n, lo_is_addr;
  logic [7:0]  hi_addr;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_P/2) clk = ~clk;

  xbus_strobe_gen i_xbus_strobe_gen (
    .clk(clk), .rst(rst), .slot(slot), .ea_pin(ea_pin), .fetch_addr(fetch_addr),
    .xdata_cyc(xdata_cyc), .xdata_wide(xdata_wide), .dptr_hi(dptr_hi),
    .tbl_rd(tbl_rd), .ale_off(ale_off), .p2_reg(p2_reg),
    .ale(ale), .psen_n(psen_n), .lo_is_addr(lo_is_addr), .hi_addr(hi_addr)
  );

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_ext(bit ea, logic [15:0] fa);
    return !ea || (fa >= 16'h2000);
  endfunction

  function automatic bit exp_ale(int s, bit ce, bit xd, bit tb, bit off);
    bit first = (s == 1 || s == 2);
    bit lat   = first || s == 7 || s == 8;
    bit raw   = lat && !(first && xd);
    bit gate  = !off || ce || xd || tb;
    return gate ? raw : 1'b1;
  endfunction

  function automatic bit exp_psen_n(int s, bit ce, bit xd);
    bit rd = (s >= 3 && s <= 5) || (s >= 9 && s <= 11);
    return !(ce && !xd && rd);
  endfunction

  function automatic bit exp_lo(int s, bit ce, bit xd);
    if (xd) return (s >= 6 && s <= 8);
    if (ce) return (s <= 2) || (s >= 6 && s <= 8);
    return 1'b0;
  endfunction

  function automatic logic [7:0] exp_hi(bit ce, bit xd, bit wd, logic [15:0] fa,
                                        logic [7:0] dh, logic [7:0] p2);
    if (xd) return wd ? dh : p2;
    if (ce) return fa[15:8];
    return p2;
  endfunction

  // one machine cycle with flags held; p2/dptr vary per slot
  task automatic run_cycle(bit ea, logic [15:0] fa, bit xd, bit wd, bit tb, bit off,
                           string psen_tag);
    for (int s = 0; s < 12; s++) begin
      bit ce;
      bit e_ale, e_psen, e_lo;
      logic [7:0] e_hi;
      string t_ale, t_psen, t_hi;
      slot = 4'(s); ea_pin = ea; fetch_addr = fa; xdata_cyc = xd; xdata_wide = wd;
      tbl_rd = tb; ale_off = off;
      p2_reg = 8'($urandom); dptr_hi = 8'($urandom);
      ce = exp_ext(ea, fa);
      e_ale  = exp_ale(s, ce, xd, tb, off);
      e_psen = exp_psen_n(s, ce, xd);
      e_lo   = exp_lo(s, ce, xd);
      e_hi   = exp_hi(ce, xd, wd, fa, dptr_hi, p2_reg);
      if (xd) t_ale = "R3";
      else if (off && ce) t_ale = "R5";
      else if (off) t_ale = "R4";
      else t_ale = "R2";
      if (psen_tag != "") t_psen = psen_tag;
      else t_psen = (xd || !ce) ? "R7" : "R6";
      t_hi = xd ? (wd ? "R9" : "R10") : "R11";
      @(posedge clk);
      @(negedge clk);
      check({t_ale, " ale"}, int'(ale), int'(e_ale));
      check({t_psen, " psen_n"}, int'(psen_n), int'(e_psen));
      check("R12 lo_is_addr", int'(lo_is_addr), int'(e_lo));
      check({t_hi, " hi_addr"}, int'(hi_addr), int'(e_hi));
    end
  endtask

  initial begin
    #(CLK_P * WATCHDOG_CYC);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: slot 1 with external code would raise ale if reset were ignored
    slot = 4'd1; ea_pin = 1'b0; fetch_addr = 16'hABCD; p2_reg = 8'h5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ale", int'(ale), 0);
    check("R1 psen_n", int'(psen_n), 1);
    check("R1 lo_is_addr", int'(lo_is_addr), 0);
    check("R1 hi_addr", int'(hi_addr), 0);
    rst = 1'b0;

    // directed corners
    run_cycle(1'b1, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b0, "");      // R2 free running
    run_cycle(1'b1, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b1, "");      // R4 silenced, held high
    run_cycle(1'b1, 16'h0100, 1'b0, 1'b0, 1'b1, 1'b1, "");      // R4 table read reopens
    run_cycle(1'b1, 16'h0100, 1'b1, 1'b1, 1'b0, 1'b1, "");      // R4/R3 data move reopens
    run_cycle(1'b0, 16'h0040, 1'b0, 1'b0, 1'b0, 1'b1, "R8");    // R5 + R8 strap low
    run_cycle(1'b1, 16'h1FFF, 1'b0, 1'b0, 1'b0, 1'b0, "R8");    // R8 last internal byte
    run_cycle(1'b1, 16'h2000, 1'b0, 1'b0, 1'b0, 1'b1, "R8");    // R8 first external byte
    run_cycle(1'b0, 16'hF123, 1'b1, 1'b1, 1'b0, 1'b0, "");      // R3 R7 R9 external code
    run_cycle(1'b0, 16'hF123, 1'b1, 1'b0, 1'b0, 1'b0, "");      // R10 narrow
    run_cycle(1'b1, 16'h0800, 1'b1, 1'b0, 1'b0, 1'b0, "");      // R10 internal code
    run_cycle(1'b0, 16'h3456, 1'b0, 1'b0, 1'b0, 1'b0, "");      // R6 R11 R12

    // constrained random machine cycles
    for (int c = 0; c < RAND_CYCLES; c++) begin
      bit ea = ($urandom_range(0, 3) != 0);
      logic [15:0] fa;
      bit xd = ($urandom_range(0, 2) == 0);
      bit wd = 1'($urandom);
      bit tb = ($urandom_range(0, 4) == 0);
      bit off = 1'($urandom);
      case ($urandom_range(0, 3))
        0: fa = 16'($urandom_range(16'h1FF0, 16'h200F));
        1: fa = 16'($urandom_range(0, 16'h1FFF));
        default: fa = 16'($urandom);
      endcase
      run_cycle(ea, fa, xd, wd, tb, off, "");
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule